// File: doc/BRIEF.md
# Delegated Interrupt Pending and Enable Register Bank

This block holds the machine-level interrupt pending, interrupt enable and interrupt delegation state of a processor hart. It also holds the supervisor-to-user delegation mask. It presents three views of pending and enable: machine, supervisor and user. Each lower view is formed combinationally as the AND of the view above it and the relevant delegation mask, so a lower view never holds state of its own. Hardware interrupt lines enter on one vector and appear in the machine pending view.

A single CSR write port carries the privilege of the writer, a register select and the data. Each write is filtered per bit. The filter depends on the writer's privilege, the register, the delegation state before the write, and two configuration inputs that say whether user mode and user-level interrupts exist. A write takes effect at the next rising clock edge. Reads are live on the outputs. Interrupt arbitration and trap entry belong to neighbouring logic.

Top module: `irq_csr_bank`

## Requirements
- R1: While rst_ni is low and after its release, all stored pending, enable and delegation bits are zero, and the outputs show only hardware lines.
- R2: The machine delegation mask keeps only bits 9, 8, 5, 4, 1 and 0, and bits 11, 7 and 3 always read zero. The user delegation mask keeps only bits 8, 4 and 0 and is written by machine (wr_priv_i=11) or supervisor (01) with wr_sel_i=11. The machine delegation mask is written only by machine with wr_sel_i=10.
- R3: A machine write to pending (wr_sel_i=00) loads bits 9, 5 and 1. It loads bits 8, 4 and 0 only when both umode_en_i and uirq_en_i are high.
- R4: A machine write to enable (wr_sel_i=01) loads bits 11, 9, 7, 5, 3 and 1. It loads bits 8, 4 and 0 only when both configuration inputs are high.
- R5: The supervisor pending and enable outputs equal the machine view ANDed with the machine delegation mask. All other bits read zero.
- R6: A supervisor write to pending changes bit 1 only if it is delegated. It changes bits 8 and 0 only if each is delegated and uirq_en_i is high. Bits 9 and 5 never change.
- R7: A supervisor write to enable changes each of bits 9, 5 and 1 where delegated. It changes bits 8, 4 and 0 where delegated and uirq_en_i is high.
- R8: The user pending and enable outputs equal the supervisor view ANDed with the user delegation mask.
- R9: A user write (wr_priv_i=00) to pending changes only bit 0. It does so only when that bit is delegated at both levels and uirq_en_i is high.
- R10: A user write to enable changes bits 8, 4 and 0 only where each is delegated at both levels and uirq_en_i is high.
- R11: Hardware lines on irq_src_i are ORed into the machine pending view at their bit positions. Bits 11, 7 and 3 of pending follow only those lines and no write alters them.
- R12: Writes with wr_priv_i=10 change nothing. User writes to either delegation mask and supervisor writes to the machine delegation mask also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| umode_en_i | input | 1 | User mode exists |
| uirq_en_i | input | 1 | User-level interrupts exist |
| irq_src_i | input | 12 | Hardware interrupt lines at layout positions |
| wr_valid_i | input | 1 | Write strobe |
| wr_priv_i | input | 2 | Writer privilege: 00 user, 01 supervisor, 11 machine |
| wr_sel_i | input | 2 | 00 pending, 01 enable, 10 machine delegation, 11 user delegation |
| wr_data_i | input | 12 | Write data |
| m_pend_o | output | 12 | Machine pending view |
| m_en_o | output | 12 | Machine enable view |
| m_deleg_o | output | 12 | Machine delegation mask |
| s_pend_o | output | 12 | Supervisor pending view |
| s_en_o | output | 12 | Supervisor enable view |
| s_deleg_o | output | 12 | User delegation mask |
| u_pend_o | output | 12 | User pending view |
| u_en_o | output | 12 | User enable view |

## Verification
A wrong write-mask bit leaves a stored bit wrong. That shows on the machine view one cycle after the offending write, and on a lower view only while the bit is delegated. For this reason the bench sets full delegation before it checks the lower-privilege write paths. A wrong delegation bit shows at once as a missing or extra bit in the supervisor or user view. The bench compares all eight outputs against its model on every clock, so any divergence is caught on the first cycle it appears.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int IRQ_W = 12;
  localparam int B_USI = 0;
  localparam int B_SSI = 1;
  localparam int B_MSI = 3;
  localparam int B_UTI = 4;
  localparam int B_STI = 5;
  localparam int B_MTI = 7;
  localparam int B_UEI = 8;
  localparam int B_SEI = 9;
  localparam int B_MEI = 11;

  typedef logic [IRQ_W-1:0] irq_vec_t;

  localparam irq_vec_t M_LVL   = irq_vec_t'((1 << B_MSI) | (1 << B_MTI) | (1 << B_MEI));
  localparam irq_vec_t S_LVL   = irq_vec_t'((1 << B_SSI) | (1 << B_STI) | (1 << B_SEI));
  localparam irq_vec_t U_LVL   = irq_vec_t'((1 << B_USI) | (1 << B_UTI) | (1 << B_UEI));
  localparam irq_vec_t ALL_LVL = M_LVL | S_LVL | U_LVL;
  localparam irq_vec_t S_PEND  = irq_vec_t'(1 << B_SSI);
  localparam irq_vec_t SU_PEND = irq_vec_t'((1 << B_USI) | (1 << B_UEI));
  localparam irq_vec_t U_PEND  = irq_vec_t'(1 << B_USI);

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    SEL_PEND   = 2'b00,
    SEL_EN     = 2'b01,
    SEL_MDELEG = 2'b10,
    SEL_SDELEG = 2'b11
  } sel_e;

  typedef struct packed {
    irq_vec_t pend;
    irq_vec_t en;
    irq_vec_t mdel;
    irq_vec_t sdel;
  } wmask_t;
endpackage

// File: rtl/irq_wmask.sv
module irq_wmask
  import irq_csr_pkg::*;
(
  input  logic     valid_i,
  input  logic [1:0] priv_i,
  input  logic [1:0] sel_i,
  input  logic     umode_en_i,
  input  logic     uirq_en_i,
  input  irq_vec_t mdel_i,
  input  irq_vec_t sdel_i,
  output wmask_t   mask_o
);
  irq_vec_t u_mach;  // user bits visible to machine writes
  irq_vec_t u_sup;   // user bits visible to supervisor/user writes
  irq_vec_t pend_m, en_m;
  priv_e    priv;
  sel_e     sel;

  assign priv   = priv_e'(priv_i);
  assign sel    = sel_e'(sel_i);
  assign u_mach = (umode_en_i && uirq_en_i) ? U_LVL : '0;
  assign u_sup  = uirq_en_i ? U_LVL : '0;

  always_comb begin
    pend_m = '0;
    en_m   = '0;
    unique case (priv)
      PRIV_M: begin
        pend_m = S_LVL | u_mach;
        en_m   = M_LVL | S_LVL | u_mach;
      end
      PRIV_S: begin
        pend_m = (S_PEND | (SU_PEND & u_sup)) & mdel_i;
        en_m   = (S_LVL | u_sup) & mdel_i;
      end
      PRIV_U: begin
        pend_m = U_PEND & u_sup & sdel_i & mdel_i;
        en_m   = u_sup & sdel_i & mdel_i;
      end
      default: begin
        pend_m = '0;
        en_m   = '0;
      end
    endcase
  end

  always_comb begin
    mask_o = '0;
    if (valid_i) begin
      unique case (sel)
        SEL_PEND:   mask_o.pend = pend_m;
        SEL_EN:     mask_o.en   = en_m;
        SEL_MDELEG: mask_o.mdel = (priv == PRIV_M) ? (S_LVL | U_LVL) : '0;
        SEL_SDELEG: mask_o.sdel = (priv == PRIV_M || priv == PRIV_S) ? U_LVL : '0;
        default:    mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_mreg.sv
module irq_mreg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o[i] <= 1'b0;
      else if (wmask_i[i]) q_o[i] <= wdata_i[i];
    end
  end
endmodule

// File: rtl/irq_view.sv
module irq_view #(
  parameter int W = 12
) (
  input  logic [W-1:0] upper_i,
  input  logic [W-1:0] deleg_i,
  output logic [W-1:0] lower_o
);
  assign lower_o = upper_i & deleg_i;
endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
  import irq_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             umode_en_i,
  input  logic             uirq_en_i,
  input  logic [IRQ_W-1:0] irq_src_i,
  input  logic             wr_valid_i,
  input  logic [1:0]       wr_priv_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IRQ_W-1:0] wr_data_i,
  output logic [IRQ_W-1:0] m_pend_o,
  output logic [IRQ_W-1:0] m_en_o,
  output logic [IRQ_W-1:0] m_deleg_o,
  output logic [IRQ_W-1:0] s_pend_o,
  output logic [IRQ_W-1:0] s_en_o,
  output logic [IRQ_W-1:0] s_deleg_o,
  output logic [IRQ_W-1:0] u_pend_o,
  output logic [IRQ_W-1:0] u_en_o
);
  wmask_t   wm;
  irq_vec_t pend_q, en_q, mdel_q, sdel_q;

  irq_wmask i_wmask (
    .valid_i    (wr_valid_i),
    .priv_i     (wr_priv_i),
    .sel_i      (wr_sel_i),
    .umode_en_i (umode_en_i),
    .uirq_en_i  (uirq_en_i),
    .mdel_i     (mdel_q),
    .sdel_i     (sdel_q),
    .mask_o     (wm)
  );

  irq_mreg #(.W(IRQ_W)) i_pend (
    .clk_i, .rst_ni, .wmask_i(wm.pend), .wdata_i(wr_data_i), .q_o(pend_q));
  irq_mreg #(.W(IRQ_W)) i_en (
    .clk_i, .rst_ni, .wmask_i(wm.en),   .wdata_i(wr_data_i), .q_o(en_q));
  irq_mreg #(.W(IRQ_W)) i_mdel (
    .clk_i, .rst_ni, .wmask_i(wm.mdel), .wdata_i(wr_data_i), .q_o(mdel_q));
  irq_mreg #(.W(IRQ_W)) i_sdel (
    .clk_i, .rst_ni, .wmask_i(wm.sdel), .wdata_i(wr_data_i), .q_o(sdel_q));

  // hardware lines merge into the machine view; stored bits never cover M positions
  assign m_pend_o  = pend_q | (irq_src_i & ALL_LVL);
  assign m_en_o    = en_q;
  assign m_deleg_o = mdel_q;
  assign s_deleg_o = sdel_q;

  irq_view #(.W(IRQ_W)) i_s_pend (.upper_i(m_pend_o), .deleg_i(mdel_q), .lower_o(s_pend_o));
  irq_view #(.W(IRQ_W)) i_s_en   (.upper_i(en_q),     .deleg_i(mdel_q), .lower_o(s_en_o));
  irq_view #(.W(IRQ_W)) i_u_pend (.upper_i(s_pend_o), .deleg_i(sdel_q), .lower_o(u_pend_o));
  irq_view #(.W(IRQ_W)) i_u_en   (.upper_i(s_en_o),   .deleg_i(sdel_q), .lower_o(u_en_o));
endmodule

// File: rtl/irq_csr_chk.sv
module irq_csr_chk
  import irq_csr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IRQ_W-1:0] irq_src_i,
  input logic             wr_valid_i,
  input logic [1:0]       wr_priv_i,
  input logic [1:0]       wr_sel_i,
  input logic [IRQ_W-1:0] wr_data_i,
  input logic [IRQ_W-1:0] pend_q,
  input logic [IRQ_W-1:0] en_q,
  input logic [IRQ_W-1:0] m_pend_o,
  input logic [IRQ_W-1:0] m_deleg_o,
  input logic [IRQ_W-1:0] s_pend_o,
  input logic [IRQ_W-1:0] s_en_o,
  input logic [IRQ_W-1:0] s_deleg_o,
  input logic [IRQ_W-1:0] u_pend_o,
  input logic [IRQ_W-1:0] u_en_o
);
  localparam irq_vec_t SEI_STI = irq_vec_t'((1 << B_SEI) | (1 << B_STI));

  // R2
  mdel_m_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_deleg_o & M_LVL) == '0);

  // R3
  m_pend_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_priv_i == 2'b11 && wr_sel_i == 2'b00)
    |=> ((pend_q & S_LVL) == ($past(wr_data_i) & S_LVL)));

  // R5
  s_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s_pend_o | s_en_o) & ~m_deleg_o) == '0);

  // R6
  s_pend_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_priv_i == 2'b01 && wr_sel_i == 2'b00)
    |=> ((pend_q & SEI_STI) == ($past(pend_q) & SEI_STI)));

  // R8
  u_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((u_pend_o | u_en_o) & ~s_deleg_o) == '0);

  // R9
  u_pend_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_priv_i == 2'b00 && wr_sel_i == 2'b00)
    |=> ((pend_q & ~U_PEND) == ($past(pend_q) & ~U_PEND)));

  // R11
  hw_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_pend_o & M_LVL) == (irq_src_i & M_LVL));

  // R12
  rsv_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_priv_i == 2'b10)
    |=> ($stable(pend_q) && $stable(en_q) && $stable(m_deleg_o) && $stable(s_deleg_o)));
endmodule

bind irq_csr_bank irq_csr_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_src_i  (irq_src_i),
  .wr_valid_i (wr_valid_i),
  .wr_priv_i  (wr_priv_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .pend_q     (pend_q),
  .en_q       (en_q),
  .m_pend_o   (m_pend_o),
  .m_deleg_o  (m_deleg_o),
  .s_pend_o   (s_pend_o),
  .s_en_o     (s_en_o),
  .s_deleg_o  (s_deleg_o),
  .u_pend_o   (u_pend_o),
  .u_en_o     (u_en_o)
);

// File: tb/test_irq_csr_bank.sv
module test_irq_csr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        umode_en = 1'b0, uirq_en = 1'b0;
  logic [11:0] src = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_priv = '0, wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] m_pend, m_en, m_deleg, s_pend, s_en, s_deleg, u_pend, u_en;

  int    n_checks = 0, n_errors = 0;
  bit    run = 0;
  string cur_tag = "R1";

  // behavioural model state
  logic [11:0] mp = '0, me = '0, md = '0, sd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_csr_bank i_irq_csr_bank (
    .clk_i(clk), .rst_ni(rst_n), .umode_en_i(umode_en), .uirq_en_i(uirq_en),
    .irq_src_i(src), .wr_valid_i(wr_valid), .wr_priv_i(wr_priv), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .m_pend_o(m_pend), .m_en_o(m_en), .m_deleg_o(m_deleg),
    .s_pend_o(s_pend), .s_en_o(s_en), .s_deleg_o(s_deleg), .u_pend_o(u_pend), .u_en_o(u_en)
  );

  function automatic bit is_m(int b); return b == 3 || b == 7 || b == 11; endfunction
  function automatic bit is_s(int b); return b == 1 || b == 5 || b == 9;  endfunction
  function automatic bit is_u(int b); return b == 0 || b == 4 || b == 8;  endfunction

  task automatic cmp(string what, logic [11:0] act, logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (run) begin
    logic [11:0] e_mp, e_sp, e_se;
    e_mp = mp | (src & 12'hBBB);
    e_sp = e_mp & md;
    e_se = me & md;
    cmp("m_pend",  m_pend,  e_mp);
    cmp("m_en",    m_en,    me);
    cmp("m_deleg", m_deleg, md);
    cmp("s_pend",  s_pend,  e_sp);
    cmp("s_en",    s_en,    e_se);
    cmp("s_deleg", s_deleg, sd);
    cmp("u_pend",  u_pend,  e_sp & sd);
    cmp("u_en",    u_en,    e_se & sd);
  end

  task automatic model_write(logic [1:0] p, logic [1:0] s, logic [11:0] d);
    logic [11:0] md_old, sd_old;
    bit both;
    md_old = md;
    sd_old = sd;
    both = umode_en && uirq_en;
    for (int b = 0; b < 12; b++) begin
      bit w;
      w = 0;
      case (s)
        2'b00: begin
          if (p == 2'b11) w = is_s(b) || (is_u(b) && both);
          else if (p == 2'b01) w = md_old[b] && (b == 1 || (uirq_en && (b == 0 || b == 8)));
          else if (p == 2'b00) w = (b == 0) && uirq_en && sd_old[0] && md_old[0];
          if (w) mp[b] = d[b];
        end
        2'b01: begin
          if (p == 2'b11) w = is_m(b) || is_s(b) || (is_u(b) && both);
          else if (p == 2'b01) w = md_old[b] && (is_s(b) || (is_u(b) && uirq_en));
          else if (p == 2'b00) w = is_u(b) && uirq_en && sd_old[b] && md_old[b];
          if (w) me[b] = d[b];
        end
        2'b10: begin
          if (p == 2'b11) w = is_s(b) || is_u(b);
          if (w) md[b] = d[b];
        end
        default: begin
          if (p == 2'b11 || p == 2'b01) w = is_u(b);
          if (w) sd[b] = d[b];
        end
      endcase
    end
  endtask

  task automatic wr(string tag, logic [1:0] p, logic [1:0] s, logic [11:0] d);
    @(posedge clk); #1;
    cur_tag = tag;
    wr_valid = 1'b1; wr_priv = p; wr_sel = s; wr_data = d;
    @(posedge clk); #1;
    model_write(p, s, d);
    wr_valid = 1'b0;
  endtask

  task automatic set_src(string tag, logic [11:0] v);
    @(posedge clk); #1;
    cur_tag = tag;
    src = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk);
    cur_tag = "R1";
    cmp("reset m_pend", m_pend, 12'h000);
    cmp("reset m_en", m_en, 12'h000);
    cmp("reset m_deleg", m_deleg, 12'h000);
    #1 rst_n = 1'b1;
    run = 1;
    idle(2);

    // R2: delegation masks
    wr("R2", 2'b11, 2'b10, 12'hFFF);
    wr("R2", 2'b11, 2'b11, 12'hFFF);
    wr("R2", 2'b01, 2'b11, 12'h0EE);
    wr("R2", 2'b11, 2'b11, 12'hFFF);

    // R3/R4 without user support, then with
    wr("R3", 2'b11, 2'b00, 12'hFFF);
    wr("R4", 2'b11, 2'b01, 12'hFFF);
    umode_en = 1'b1; uirq_en = 1'b1;
    wr("R3", 2'b11, 2'b00, 12'hFFF);
    wr("R3", 2'b11, 2'b00, 12'h000);
    wr("R4", 2'b11, 2'b01, 12'hFFF);
    wr("R4", 2'b11, 2'b01, 12'h000);

    // R6/R7/R5 with full delegation
    wr("R6", 2'b01, 2'b00, 12'hFFF);
    wr("R7", 2'b01, 2'b01, 12'hFFF);
    idle(2);
    wr("R6", 2'b01, 2'b00, 12'h000);
    wr("R5", 2'b11, 2'b10, 12'h020);
    wr("R7", 2'b01, 2'b01, 12'h000);
    wr("R5", 2'b11, 2'b00, 12'hFFF);
    idle(2);

    // R8/R9/R10
    wr("R8", 2'b11, 2'b10, 12'hFFF);
    wr("R9", 2'b11, 2'b00, 12'h000);
    wr("R9", 2'b00, 2'b00, 12'hFFF);
    wr("R10", 2'b00, 2'b01, 12'hFFF);
    wr("R8", 2'b11, 2'b11, 12'h010);
    wr("R10", 2'b00, 2'b01, 12'h000);
    wr("R9", 2'b00, 2'b00, 12'h000);
    wr("R8", 2'b11, 2'b11, 12'h111);

    // uirq off: supervisor/user cannot touch user bits; umode off alone
    uirq_en = 1'b0;
    wr("R7", 2'b11, 2'b01, 12'hFFF);
    wr("R7", 2'b01, 2'b01, 12'h000);
    wr("R10", 2'b00, 2'b01, 12'h000);
    wr("R6", 2'b01, 2'b00, 12'h000);
    umode_en = 1'b0; uirq_en = 1'b1;
    wr("R3", 2'b11, 2'b00, 12'h111);
    wr("R6", 2'b01, 2'b00, 12'h101);
    umode_en = 1'b1;

    // R11: hardware lines
    set_src("R11", 12'h888);
    idle(2);
    wr("R11", 2'b11, 2'b00, 12'h000);
    wr("R11", 2'b11, 2'b00, 12'hFFF);
    set_src("R11", 12'h3BB);
    idle(2);
    set_src("R11", 12'h000);

    // R12: ignored writes
    wr("R12", 2'b10, 2'b00, 12'h000);
    wr("R12", 2'b10, 2'b01, 12'h555);
    wr("R12", 2'b10, 2'b10, 12'h000);
    wr("R12", 2'b01, 2'b10, 12'h000);
    wr("R12", 2'b00, 2'b10, 12'h000);
    wr("R12", 2'b00, 2'b11, 12'h000);
    idle(2);

    // R1: reset clears everything again
    @(posedge clk); #1;
    cur_tag = "R1";
    rst_n = 1'b0;
    mp = '0; me = '0; md = '0; sd = '0;
    idle(2);
    #1 rst_n = 1'b1;
    idle(3);

    run = 0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule